// File: doc/BRIEF.md
# Field Difference Accumulator

This block gauges how alike two successive video fields are, as an input to line-flicker control. On every pixel clock it receives one 8-bit luminance sample from each of two field streams, together with a qualifier that marks active video. For each qualified pixel it takes the absolute difference of the upper four bits of the two samples. It adds that difference into a saturating per-field accumulator.

A field-boundary strobe arrives asynchronously during field blanking. The block synchronizes this strobe and detects its rising edge. On that edge it copies the sixteen most significant accumulator bits into a result register and restarts the accumulator from zero. A host reads the result one byte at a time through a simple read port. Reading the upper byte clears the result, so a read of the low byte followed by the high byte returns one consistent value.

Top module: `field_diff_acc`

## Requirements
- R1: While reset is asserted and immediately after it is released, the accumulator, the result register and `rd_data` are all zero.
- R2: A pixel pair is added to the accumulator only in a cycle where `active` is high. Samples presented while `active` is low have no effect on the sum.
- R3: Each qualified pixel contributes |a[7:4] − b[7:4]|, a value from 0 to 15. The four low bits of each sample are ignored.
- R4: The accumulator is `ACC_W` bits wide (default 24). When a sum would exceed all-ones, it holds at all-ones instead of wrapping.
- R5: A rising edge on `fld_strobe` passes through a two-flop synchronizer. Two clock edges after the strobe is sampled high, the result register is loaded with accumulator bits [ACC_W-1:ACC_W-16] (bits 23..8 by default).
- R6: In the capture cycle the accumulator is reset to zero, and the pixel of that cycle is discarded. The next field's sum therefore starts fresh.
- R7: A read with `rd_en` high and `rd_addr` = 0x80 returns result bits 7..0 on `rd_data`. A read at `rd_addr` = 0x81 returns bits 15..8. `rd_data` is valid one clock after the read cycle.
- R8: A read at 0x81 clears the result register to zero after returning the high byte. A read at 0x80 leaves the result unchanged. When a capture and a clearing read occur in the same cycle, the capture wins.
- R9: A read at any other address returns 0 and leaves the result register unchanged.
- R10: Capture is edge-triggered. Holding `fld_strobe` high for many cycles causes exactly one capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_a | input | 8 | Luminance sample from the first field stream |
| pix_b | input | 8 | Luminance sample from the second field stream |
| active | input | 1 | High during active video |
| fld_strobe | input | 1 | Asynchronous field-boundary strobe; its rising edge triggers a capture |
| rd_en | input | 1 | Host read request, one cycle per byte |
| rd_addr | input | 8 | Read index: 0x80 selects the low byte, 0x81 the high byte |
| rd_data | output | 8 | Registered read data |

## Verification
The bench first runs directed fields. These fields pair full-scale upper-nibble differences with samples that differ only in their low nibble, which separates a correct 4-bit comparison from a full-width one. Fields with large differences hidden under a low `active` separate proper qualification from unconditional summing. A long run of maximum differences tells saturation apart from wraparound. A strobe held high during ongoing pixels tells edge capture apart from level capture. Random fields with random qualifiers then test the general sum against a bench model, and read orderings at 0x80, 0x81 and unused indices distinguish clear-on-high-read from clear-on-any-read.

// File: rtl/fda_pkg.sv
package fda_pkg;
  localparam int RES_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [7:0] IDX_LO = 8'h80;
  localparam logic [7:0] IDX_HI = 8'h81;
endpackage

// File: rtl/fda_strobe_sync.sv
module fda_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= strobe_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], strobe_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fda_accum.sv
module fda_accum #(
  parameter int PIX_W = 8,
  parameter int CMP_W = 4,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic             active,
  input  logic             restart,
  output logic [ACC_W-1:0] acc
);
  logic [CMP_W-1:0] nib_a, nib_b, diff;
  logic [ACC_W:0]   sum_ext;
  logic [ACC_W-1:0] next_acc;

  assign nib_a = pix_a[PIX_W-1 -: CMP_W];
  assign nib_b = pix_b[PIX_W-1 -: CMP_W];
  assign diff  = (nib_a >= nib_b) ? (nib_a - nib_b) : (nib_b - nib_a);

  assign sum_ext  = {1'b0, acc} + {{(ACC_W+1-CMP_W){1'b0}}, diff};
  assign next_acc = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || restart) acc <= '0;
    else if (active)    acc <= next_acc;
  end
endmodule

// File: rtl/fda_readout.sv
module fda_readout
  import fda_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [RES_W-1:0] cap_val,
  input  logic             rd_en,
  input  logic [7:0]       rd_addr,
  output logic [RES_W-1:0] result,
  output logic [7:0]       rd_data
);
  logic hit_lo, hit_hi;
  assign hit_lo = rd_en && (rd_addr == IDX_LO);
  assign hit_hi = rd_en && (rd_addr == IDX_HI);

  always_ff @(posedge clk) begin
    if (rst)         result <= '0;
    else if (cap)    result <= cap_val;
    else if (hit_hi) result <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (hit_lo) rd_data <= result[BYTE_W-1:0];
    else if (hit_hi) rd_data <= result[RES_W-1 -: BYTE_W];
    else if (rd_en)  rd_data <= '0;
  end
endmodule

// File: rtl/field_diff_acc.sv
module field_diff_acc
  import fda_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int CMP_W       = 4,
  parameter int ACC_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_a,
  input  logic [PIX_W-1:0] pix_b,
  input  logic             active,
  input  logic             fld_strobe,
  input  logic             rd_en,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data
);
  logic             cap_pulse;
  logic [ACC_W-1:0] acc_q;
  logic [RES_W-1:0] result_q;

  fda_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_in(fld_strobe), .rise(cap_pulse)
  );

  fda_accum #(.PIX_W(PIX_W), .CMP_W(CMP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .pix_a(pix_a), .pix_b(pix_b),
    .active(active), .restart(cap_pulse), .acc(acc_q)
  );

  fda_readout u_rd (
    .clk(clk), .rst(rst), .cap(cap_pulse),
    .cap_val(acc_q[ACC_W-1 -: RES_W]),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .result(result_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/field_diff_acc_chk.sv
module field_diff_acc_chk #(
  parameter int ACC_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             active,
  input logic             rd_en,
  input logic [7:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic             cap,
  input logic [ACC_W-1:0] acc,
  input logic [15:0]      result
);
  localparam logic [ACC_W-1:0] STEP_MAX = {{(ACC_W-4){1'b0}}, 4'd15};

  p_reset_r1: assert property (@(posedge clk) rst |=> (rd_data == 8'd0 && result == 16'd0 && acc == '0));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!active && !cap) |=> acc == $past(acc));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (active && !cap) |=> (acc >= $past(acc)) && ((acc - $past(acc)) <= STEP_MAX));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (acc == {ACC_W{1'b1}} && !cap) |=> acc == {ACC_W{1'b1}});

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    cap |=> result == $past(acc[ACC_W-1 -: 16]));

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    cap |=> acc == '0);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 8'h81 && !cap) |=> result == 16'd0);

  p_other_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != 8'h80 && rd_addr != 8'h81 && !cap) |=> (rd_data == 8'd0 && $stable(result)));

  p_single_r10: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cap);
endmodule

bind field_diff_acc field_diff_acc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .active(active), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .cap(cap_pulse), .acc(acc_q), .result(result_q)
);

// File: tb/tb_field_diff_acc.sv
module tb_field_diff_acc;
  localparam int ACC_W = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pix_a = '0, pix_b = '0;
  logic       active = 1'b0, fld_strobe = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  field_diff_acc #(.ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .pix_a(pix_a), .pix_b(pix_b), .active(active),
    .fld_strobe(fld_strobe), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  // bench model built from the requirements
  logic [ACC_W-1:0] m_acc;
  logic [15:0]      m_res;
  logic             m_s1, m_s2, m_s3;

  function automatic int nib_diff(logic [7:0] a, logic [7:0] b);
    int d = int'(a[7:4]) - int'(b[7:4]);
    return (d < 0) ? -d : d;
  endfunction

  function automatic logic [ACC_W-1:0] sat_add(logic [ACC_W-1:0] acc, int d);
    longint s = longint'(acc) + longint'(d);
    longint mx = (longint'(1) << ACC_W) - 1;
    return (s > mx) ? ACC_W'(mx) : ACC_W'(s);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_res = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic cap;
      cap = m_s2 & ~m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = fld_strobe;
      if (cap) begin
        m_res = m_acc[ACC_W-1 -: 16];
        m_acc = '0;
      end else begin
        if (rd_en && rd_addr == 8'h81) m_res = '0;
        if (active) m_acc = sat_add(m_acc, nib_diff(pix_a, pix_b));
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pixel(logic [7:0] a, logic [7:0] b, logic act);
    @(negedge clk);
    pix_a = a; pix_b = b; active = act;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) pixel(8'h00, 8'h00, 1'b0);
  endtask

  task automatic strobe(int hold);
    @(negedge clk);
    active = 1'b0; fld_strobe = 1'b1;
    for (int i = 0; i < hold; i++) @(negedge clk);
    fld_strobe = 1'b0;
    idle(3);
  endtask

  task automatic do_read(logic [7:0] addr, output logic [7:0] got, output logic [7:0] exp);
    @(negedge clk);
    active = 1'b0; rd_en = 1'b1; rd_addr = addr;
    exp = (addr == 8'h80) ? m_res[7:0] : (addr == 8'h81) ? m_res[15:8] : 8'h00;
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data;
  endtask

  task automatic read_chk(string req, logic [7:0] addr, int fixed_exp);
    logic [7:0] got, exp;
    do_read(addr, got, exp);
    check(req, got, (fixed_exp >= 0) ? fixed_exp : int'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    read_chk("R1 lo", 8'h80, 0);
    read_chk("R1 hi", 8'h81, 0);

    // R3: 64 pixels of full nibble difference, 64 differing only in low nibble
    for (int i = 0; i < 64; i++) pixel(8'hF3, 8'h0C, 1'b1);
    for (int i = 0; i < 64; i++) pixel(8'h5F, 8'h50, 1'b1);
    strobe(2);
    read_chk("R3 lo (960>>2)", 8'h80, 240);   // R5 capture of top bits
    read_chk("R7 hi", 8'h81, 0);

    // R2: inactive differences ignored
    for (int i = 0; i < 100; i++) pixel(8'hFF, 8'h00, 1'b0);
    for (int i = 0; i < 4; i++) pixel(8'h80, 8'h00, 1'b1);
    strobe(2);
    read_chk("R2 lo", 8'h80, 8);
    // R8: low read does not clear, high read clears
    read_chk("R8 lo again", 8'h80, 8);
    read_chk("R8 hi", 8'h81, 0);
    read_chk("R8 lo after clear", 8'h80, 0);

    // R6 + R7: fresh field with a larger sum
    for (int i = 0; i < 2000; i++) pixel(8'hE0, 8'h10, 1'b1);   // 13 each = 26000
    strobe(2);
    read_chk("R6 lo", 8'h80, (26000 >> 2) & 255);
    // R9: other index returns 0, result untouched
    read_chk("R9 other", 8'h42, 0);
    read_chk("R7 hi", 8'h81, (26000 >> 2) >> 8);
    read_chk("R8 cleared", 8'h81, 0);

    // R10: strobe held high while pixels keep flowing
    for (int i = 0; i < 40; i++) pixel(8'h90, 8'h10, 1'b1);       // 8 each = 320
    @(negedge clk); fld_strobe = 1'b1;
    for (int i = 0; i < 30; i++) pixel(8'hF0, 8'h00, 1'b1);
    @(negedge clk); fld_strobe = 1'b0; active = 1'b0;
    idle(3);
    read_chk("R10 lo", 8'h80, -1);
    read_chk("R9 other 2", 8'h7F, 0);
    read_chk("R10 hi", 8'h81, -1);
    strobe(2);   // flush

    // R4: saturation
    for (int i = 0; i < 17600; i++) pixel(8'hF0, 8'h00, 1'b1);
    strobe(2);
    read_chk("R4 lo", 8'h80, 255);
    read_chk("R4 hi", 8'h81, 255);

    // random fields
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < 1500; i++)
        pixel(8'($urandom), 8'($urandom), 1'($urandom));
      strobe(1 + int'($urandom % 4));
      read_chk("R5 rand lo", 8'h80, -1);
      read_chk("R5 rand hi", 8'h81, -1);
    end
    finish_run();
  end
endmodule